// File: doc/BRIEF.md
# Command-Block Mailbox Register Interface

This block is the host-side register window of a disk controller's command path. Software prepares a command parameter block in memory. It then writes that block's 32-bit address into four byte registers and sets an "add" bit. The block hands the address to the controller's internal logic through a valid/ready strobe. When the internal logic reports a finished command, the block puts that command's address back into the same four byte registers, raises a "remove" flag and the interrupt line, and waits for software to acknowledge it.

The window is byte-wide, with its registers at odd offsets. The control/status register is asymmetric: several bits mean one thing on a read and another on a write. A one-deep holding slot absorbs a completion that arrives while the previous one is still unacknowledged. A counter limits how many submitted commands may be outstanding. A soft-reset bit clears all transfer state and then shows busy for a fixed settling time. A semaphore bit lets software claim the register set by reading it.

Top module: `cmdblk_mailbox`

## Requirements
- R1: Registers sit at odd offsets: address bytes 0..3 (least significant first) at 1, 3, 5, 7, address modifier at 9, control/status at 11, fatal code at 13. Even offsets read 0x00. After reset, every register reads 0x00 except the modifier, which reads 0x3d.
- R2: Writing control/status with bit 2 set while no add is pending snapshots the address and modifier. It raises cmd_valid from the next cycle, and bit 2 reads 1 while the add is pending. cmd_valid and bit 2 drop in the cycle after cmd_valid and cmd_ready are both high.
- R3: An add request written while an add is already pending is ignored, and the presented address does not change.
- R4: At most MAX_OUT (default 31) accepted commands may be outstanding. Once that many are outstanding, an add request is ignored. Control/status bit 7 reads 1 while any command is outstanding or pending, or while a soft reset is settling.
- R5: An accepted completion (cpl_valid and cpl_ready) loads its address into the four address byte registers, sets control/status bit 1 and raises irq. Writing bit 1 as 1 clears the remove request.
- R6: A completion that arrives while a remove request is pending is parked in one holding slot, and cpl_ready stays low while the slot is full. Clearing the current request presents the parked address at once, and bit 1 and irq stay high.
- R7: Writing control/status with bit 3 set clears the pending add, the remove request, the holding slot, the fatal code and the outstanding count. Bits 3 and 7 then read 1 for RST_CYCLES cycles, during which add requests are ignored and cpl_ready is low.
- R8: Control/status bit 0 is a semaphore. A read that finds it 0 returns 0 and sets it, so the next read returns 1. Any control/status write loads it from write-data bit 0.
- R9: A fault_valid pulse loads fault_code into the fatal register only while that register holds 0. Control/status bit 6 reads 1 whenever the register is non-zero.
- R10: When the modifier holds 0x3d (24-bit addressing), cmd_addr[31:24] is presented as zero. Any other value, for example 0x0d (32-bit addressing), presents all 32 bits.
- R11: Control/status bit 5 is a plain read/write maintenance flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from reg_addr) |
| cmd_valid | output | 1 | New command block address offered |
| cmd_ready | input | 1 | Internal side takes the command |
| cmd_addr | output | 32 | Command block address |
| cmd_amod | output | 8 | Address modifier captured with the command |
| cpl_valid | input | 1 | Completed block reported |
| cpl_ready | output | 1 | Completion can be taken |
| cpl_addr | input | 32 | Completed block address |
| fault_valid | input | 1 | Fatal fault report strobe |
| fault_code | input | 8 | Fatal fault code |
| irq | output | 1 | Remove request pending |

## Verification
Directed sequences exercise the handshake orderings. These include an add with a delayed ready and a second add written while the first still waits. They also include two back-to-back completions, which separate the direct and parked paths, and a fill to the outstanding limit followed by one more add. Random rounds vary the block address, the modifier (24-bit or 32-bit), the ready latency and the completion address. Each round checks the presented command address after masking and the read-back completion address, so a byte-lane swap or a wrong mask is told apart from a handshake fault. The soft-reset, semaphore, maintenance and fatal-code cases check the state that each one leaves behind, read through the register window.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    localparam logic [3:0] OFS_AMOD = 4'd9;
    localparam logic [3:0] OFS_CSR  = 4'd11;
    localparam logic [3:0] OFS_FERR = 4'd13;

    localparam int B_BUSY  = 7;
    localparam int B_FATAL = 6;
    localparam int B_MAINT = 5;
    localparam int B_SRST  = 3;
    localparam int B_ADD   = 2;
    localparam int B_REM   = 1;
    localparam int B_SEM   = 0;

    localparam logic [7:0] AMOD_A24 = 8'h3d;
    localparam logic [7:0] AMOD_A32 = 8'h0d;

    typedef struct packed {
        logic busy;
        logic fatal;
        logic maint;
        logic rsvd;
        logic srst;
        logic add;
        logic rem;
        logic sem;
    } csr_view_t;

    function automatic logic [3:0] byte_ofs(input int lane);
        return 4'(2 * lane + 1);
    endfunction

    function automatic logic [31:0] bus_addr(input logic [31:0] a, input logic [7:0] m);
        return (m == AMOD_A24) ? {8'h00, a[23:0]} : a;
    endfunction

endpackage

// File: rtl/cbm_submit.sv
module cbm_submit
    import cbm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_clr,
    input  logic        add_req,
    input  logic        full,
    input  logic [31:0] addr_in,
    input  logic [7:0]  amod_in,
    input  logic        cmd_ready,
    output logic        pend,
    output logic        accept,
    output logic [31:0] cmd_addr,
    output logic [7:0]  cmd_amod
);
    logic [31:0] addr_q;
    logic [7:0]  amod_q;

    assign accept   = pend && cmd_ready;
    assign cmd_addr = bus_addr(addr_q, amod_q);
    assign cmd_amod = amod_q;

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            pend   <= 1'b0;
            addr_q <= '0;
            amod_q <= AMOD_A24;
        end else if (accept) begin
            pend <= 1'b0;
        end else if (add_req && !pend && !full) begin
            pend   <= 1'b1;
            addr_q <= addr_in;
            amod_q <= amod_in;
        end
    end
endmodule

// File: rtl/cbm_retire.sv
module cbm_retire (
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_clr,
    input  logic        block,
    input  logic        clr_req,
    input  logic        cpl_valid,
    input  logic [31:0] cpl_addr,
    output logic        cpl_ready,
    output logic        taken,
    output logic        rem,
    output logic        load_en,
    output logic [31:0] load_val
);
    logic        hold_full;
    logic [31:0] hold_q;
    logic        clr_now;

    assign cpl_ready = !hold_full && !block;
    assign taken     = cpl_valid && cpl_ready;
    assign clr_now   = rem && clr_req;
    assign load_en   = !soft_clr && ((clr_now && (hold_full || taken)) || (!rem && taken));
    assign load_val  = (clr_now && hold_full) ? hold_q : cpl_addr;

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            rem       <= 1'b0;
            hold_full <= 1'b0;
            hold_q    <= '0;
        end else if (clr_now) begin
            if (hold_full)  hold_full <= 1'b0;
            else if (!taken) rem      <= 1'b0;
        end else if (!rem) begin
            if (taken) rem <= 1'b1;
        end else if (taken) begin
            hold_q    <= cpl_addr;
            hold_full <= 1'b1;
        end
    end
endmodule

// File: rtl/cbm_resetseq.sv
module cbm_resetseq #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);
    localparam int TW = $clog2(RST_CYCLES + 1);
    logic [TW-1:0] timer_q;

    assign active = (timer_q != '0);

    always_ff @(posedge clk) begin
        if (rst)          timer_q <= '0;
        else if (start)   timer_q <= TW'(RST_CYCLES);
        else if (active)  timer_q <= timer_q - 1'b1;
    end
endmodule

// File: rtl/cmdblk_mailbox.sv
module cmdblk_mailbox
    import cbm_pkg::*;
#(
    parameter int MAX_OUT    = 31,
    parameter int RST_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        cmd_valid,
    input  logic        cmd_ready,
    output logic [31:0] cmd_addr,
    output logic [7:0]  cmd_amod,
    input  logic        cpl_valid,
    output logic        cpl_ready,
    input  logic [31:0] cpl_addr,
    input  logic        fault_valid,
    input  logic [7:0]  fault_code,
    output logic        irq
);
    localparam int CW = $clog2(MAX_OUT + 1);

    logic [3:0][7:0] addr_q;
    logic [7:0]      amod_q;
    logic [7:0]      ferr_q;
    logic            maint_q, sem_q;
    logic [CW-1:0]   cnt_q;

    logic wr_csr, rd_csr, soft_clr, rst_active;
    logic add_req, clr_req, full;
    logic pend, accept, taken, rem, load_en;
    logic [31:0] load_val;
    csr_view_t csr_v;

    assign wr_csr   = reg_wr && (reg_addr == OFS_CSR);
    assign rd_csr   = reg_rd && (reg_addr == OFS_CSR);
    assign soft_clr = wr_csr && reg_wdata[B_SRST];
    assign add_req  = wr_csr && reg_wdata[B_ADD] && !rst_active;
    assign clr_req  = wr_csr && reg_wdata[B_REM];
    assign full     = (cnt_q == CW'(MAX_OUT));

    cbm_resetseq #(.RST_CYCLES(RST_CYCLES)) u_rseq (
        .clk(clk), .rst(rst), .start(soft_clr), .active(rst_active)
    );

    cbm_submit u_sub (
        .clk(clk), .rst(rst), .soft_clr(soft_clr), .add_req(add_req), .full(full),
        .addr_in(addr_q), .amod_in(amod_q), .cmd_ready(cmd_ready),
        .pend(pend), .accept(accept), .cmd_addr(cmd_addr), .cmd_amod(cmd_amod)
    );

    cbm_retire u_ret (
        .clk(clk), .rst(rst), .soft_clr(soft_clr), .block(rst_active), .clr_req(clr_req),
        .cpl_valid(cpl_valid), .cpl_addr(cpl_addr), .cpl_ready(cpl_ready), .taken(taken),
        .rem(rem), .load_en(load_en), .load_val(load_val)
    );

    assign cmd_valid = pend;
    assign irq       = rem;

    for (genvar i = 0; i < 4; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)                                           addr_q[i] <= '0;
            else if (load_en)                                  addr_q[i] <= load_val[8*i +: 8];
            else if (reg_wr && (reg_addr == byte_ofs(i)))      addr_q[i] <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            amod_q  <= AMOD_A24;
            maint_q <= 1'b0;
            sem_q   <= 1'b0;
        end else begin
            if (reg_wr && (reg_addr == OFS_AMOD)) amod_q <= reg_wdata;
            if (wr_csr) begin
                maint_q <= reg_wdata[B_MAINT];
                sem_q   <= reg_wdata[B_SEM];
            end else if (rd_csr) begin
                sem_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_clr)                  ferr_q <= '0;
        else if (fault_valid && ferr_q == '0) ferr_q <= fault_code;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            cnt_q <= '0;
        end else begin
            unique case ({accept, taken && (cnt_q != '0)})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_comb begin
        csr_v.busy  = (cnt_q != '0) || pend || rst_active;
        csr_v.fatal = (ferr_q != '0);
        csr_v.maint = maint_q;
        csr_v.rsvd  = 1'b0;
        csr_v.srst  = rst_active;
        csr_v.add   = pend;
        csr_v.rem   = rem;
        csr_v.sem   = sem_q;
        reg_rdata   = 8'h00;
        case (reg_addr)
            4'd1:     reg_rdata = addr_q[0];
            4'd3:     reg_rdata = addr_q[1];
            4'd5:     reg_rdata = addr_q[2];
            4'd7:     reg_rdata = addr_q[3];
            OFS_AMOD: reg_rdata = amod_q;
            OFS_CSR:  reg_rdata = csr_v;
            OFS_FERR: reg_rdata = ferr_q;
            default:  reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/cmdblk_mailbox_chk.sv
module cmdblk_mailbox_chk #(
    parameter int MAX_OUT = 31
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         csr_wr,
    input logic                         wd_rem,
    input logic                         wd_srst,
    input logic                         cmd_valid,
    input logic                         cmd_ready,
    input logic [31:0]                  cmd_addr,
    input logic [7:0]                   cmd_amod,
    input logic                         irq,
    input logic [$clog2(MAX_OUT+1)-1:0] outstanding
);
    localparam int CW = $clog2(MAX_OUT + 1);

    p_hold_offer_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready && !(csr_wr && wd_srst) |=> cmd_valid && $stable(cmd_addr));

    p_drop_after_take_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> !cmd_valid);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        outstanding <= CW'(MAX_OUT));

    p_remove_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        irq && !(csr_wr && (wd_rem || wd_srst)) |=> irq);

    p_soft_clear_r7: assert property (@(posedge clk) disable iff (rst)
        csr_wr && wd_srst |=> !cmd_valid && !irq && outstanding == '0);

    p_narrow_addr_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_amod == 8'h3d |-> cmd_addr[31:24] == 8'h00);
endmodule

bind cmdblk_mailbox cmdblk_mailbox_chk #(.MAX_OUT(MAX_OUT)) u_chk (
    .clk(clk), .rst(rst), .csr_wr(wr_csr), .wd_rem(reg_wdata[1]), .wd_srst(reg_wdata[3]),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_amod(cmd_amod),
    .irq(irq), .outstanding(cnt_q)
);

// File: tb/cmdblk_mailbox_test.sv
module cmdblk_mailbox_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        cmd_valid, cmd_ready = 1'b0;
    logic [31:0] cmd_addr;
    logic [7:0]  cmd_amod;
    logic        cpl_valid = 1'b0, cpl_ready;
    logic [31:0] cpl_addr = '0;
    logic        fault_valid = 1'b0;
    logic [7:0]  fault_code = '0;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    cmdblk_mailbox uut (.*);

    function automatic logic [31:0] exp_cmd(input logic [31:0] a, input logic [7:0] m);
        return (m == 8'h3d) ? {8'h00, a[23:0]} : a;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic put_addr(input logic [31:0] a);
        for (int i = 0; i < 4; i++) wr(4'(2*i+1), a[8*i +: 8]);
    endtask

    task automatic get_addr(output logic [31:0] a);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin rd(4'(2*i+1), b); a[8*i +: 8] = b; end
    endtask

    task automatic complete(input logic [31:0] a);
        @(negedge clk); cpl_valid = 1'b1; cpl_addr = a;
        @(negedge clk); cpl_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] got;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values and map
        for (int o = 1; o < 14; o += 2) begin
            rd(4'(o), rv);
            chk("R1 reset value", rv, (o == 9) ? 8'h3d : 8'h00);
        end
        rd(4'd2, rv); chk("R1 even offset", rv, 8'h00);
        wr(4'd1, 8'h5a); rd(4'd0, rv); chk("R1 filler reads zero", rv, 8'h00);
        rd(4'd1, rv); chk("R1 byte0 readback", rv, 8'h5a);

        // R8 semaphore
        wr(4'd11, 8'h00);
        rd(4'd11, rv); chk("R8 first read", rv[0], 1'b0);
        rd(4'd11, rv); chk("R8 second read", rv[0], 1'b1);
        wr(4'd11, 8'h00);
        rd(4'd11, rv); chk("R8 released", rv[0], 1'b0);

        // R11 maintenance flag
        wr(4'd11, 8'h20); rd(4'd11, rv); chk("R11 set", rv[5], 1'b1);
        wr(4'd11, 8'h00); rd(4'd11, rv); chk("R11 clear", rv[5], 1'b0);

        // R2 / R10 add with default 24-bit modifier
        put_addr(32'hAB123456);
        wr(4'd11, 8'h04);
        chk("R2 valid after add", cmd_valid, 1'b1);
        chk("R10 upper byte masked", cmd_addr, 32'h00123456);
        rd(4'd11, rv); chk("R2 add pending bit", rv[2], 1'b1);
        chk("R4 busy while pending", rv[7], 1'b1);
        // R3 second add while pending ignored
        put_addr(32'h11111111);
        wr(4'd11, 8'h04);
        chk("R3 address unchanged", cmd_addr, 32'h00123456);
        @(negedge clk); cmd_ready = 1'b1;
        @(negedge clk); cmd_ready = 1'b0;
        chk("R2 valid drops after take", cmd_valid, 1'b0);
        rd(4'd11, rv); chk("R2 pending clear", rv[2], 1'b0);
        chk("R4 busy while outstanding", rv[7], 1'b1);

        // R5 completion, R6 parked completion
        complete(32'hCAFE0001);
        chk("R5 irq raised", irq, 1'b1);
        get_addr(got); chk("R5 address loaded", got, 32'hCAFE0001);
        complete(32'hCAFE0002);
        chk("R6 ready low when slot full", cpl_ready, 1'b0);
        get_addr(got); chk("R6 current unchanged", got, 32'hCAFE0001);
        wr(4'd11, 8'h02);
        chk("R6 irq held", irq, 1'b1);
        get_addr(got); chk("R6 parked presented", got, 32'hCAFE0002);
        chk("R6 ready back", cpl_ready, 1'b1);
        wr(4'd11, 8'h02);
        chk("R5 irq cleared", irq, 1'b0);
        rd(4'd11, rv); chk("R5 remove bit clear", rv[1], 1'b0);
        chk("R4 idle not busy", rv[7], 1'b0);

        // R10 32-bit modifier
        wr(4'd9, 8'h0d);
        put_addr(32'hAB123456);
        wr(4'd11, 8'h04);
        chk("R10 full address", cmd_addr, 32'hAB123456);
        chk("R10 modifier out", cmd_amod, 8'h0d);
        @(negedge clk); cmd_ready = 1'b1;
        @(negedge clk); cmd_ready = 1'b0;
        complete(32'h0);
        wr(4'd11, 8'h02);

        // random rounds (R2, R5, R10)
        for (int k = 0; k < 30; k++) begin
            logic [31:0] a, c;
            logic [7:0]  m;
            int d;
            a = $urandom; c = $urandom; d = $urandom_range(0, 3);
            m = ($urandom_range(0, 1) != 0) ? 8'h3d : 8'h0d;
            wr(4'd9, m);
            put_addr(a);
            wr(4'd11, 8'h04);
            chk("R2 random valid", cmd_valid, 1'b1);
            chk("R10 random address", cmd_addr, exp_cmd(a, m));
            repeat (d) @(negedge clk);
            chk("R2 random hold", cmd_valid, 1'b1);
            cmd_ready = 1'b1;
            @(negedge clk); cmd_ready = 1'b0;
            chk("R2 random drop", cmd_valid, 1'b0);
            complete(c);
            get_addr(got); chk("R5 random completion", got, c);
            wr(4'd11, 8'h02);
            chk("R5 random clear", irq, 1'b0);
        end

        // R4 outstanding limit
        cmd_ready = 1'b1;
        for (int k = 0; k < 31; k++) wr(4'd11, 8'h04);
        repeat (2) @(negedge clk);
        wr(4'd11, 8'h04);
        chk("R4 add ignored at limit", cmd_valid, 1'b0);
        rd(4'd11, rv); chk("R4 busy at limit", rv[7], 1'b1);
        cmd_ready = 1'b0;

        // R9 fatal code
        @(negedge clk); fault_valid = 1'b1; fault_code = 8'h43;
        @(negedge clk); fault_code = 8'h70;
        @(negedge clk); fault_valid = 1'b0;
        rd(4'd13, rv); chk("R9 first code kept", rv, 8'h43);
        rd(4'd11, rv); chk("R9 fatal bit", rv[6], 1'b1);

        // R7 soft reset
        complete(32'h0000BEEF);
        wr(4'd11, 8'h08);
        chk("R7 irq cleared", irq, 1'b0);
        rd(4'd11, rv); chk("R7 reset bit active", rv[3], 1'b1);
        chk("R7 busy during reset", rv[7], 1'b1);
        chk("R7 completion refused", cpl_ready, 1'b0);
        wr(4'd11, 8'h04);
        chk("R7 add ignored", cmd_valid, 1'b0);
        repeat (10) @(negedge clk);
        rd(4'd11, rv); chk("R7 status after settle", rv & 8'hFE, 8'h00);
        rd(4'd13, rv); chk("R7 fatal cleared", rv, 8'h00);
        wr(4'd11, 8'h04);
        chk("R7 count cleared, add taken", cmd_valid, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule